// File: doc/BRIEF.md
# Bus Takeover Request Register

This block lets a host machine surrender its bus to an outside master under software control. It watches host bus cycles inside the video controller's register space. Two otherwise unused register slots act as commands, and only the address of the access counts. An access to the first slot raises a bus-release request. An access to the second slot withdraws it. The request leaves the block as an active-low signal that drives the host's DMA input.

The host mirrors its video controller across four 256-byte pages. The block narrows the controller's chip select so that only the first of those pages still reaches the controller. The other three pages are then free for other uses.

Decoding happens only while the original chip select is active and the phase-2 clock is high. This matters because the same address range can also map to character ROM or RAM. It also means that address changes during the video half of the cycle cannot move the request. All offsets and the page number are parameters.

Top module: `bus_takeover_reg`

## Requirements
- R1: While `rst_n` is low, `dma_req_n` is high (released). After reset it stays high until a set access is decoded.
- R2: An access at page `VID_PAGE` (address bits 15:8 = 0xD0), offset `SET_OFS` (0x31), decoded at a rising `clk` edge, drives `dma_req_n` low from that edge on.
- R3: An access at offset `CLR_OFS` (0x32) of the same page drives `dma_req_n` high from the decoding edge on.
- R4: Accesses to any other address leave `dma_req_n` unchanged. This includes offsets 0x2F, 0x30, 0x33 and 0x3F, and the mirror pages 0xD1 to 0xD3.
- R5: No access changes `dma_req_n` while `cs_n` is high or `phi2` is low.
- R6: `vid_cs_n` is low exactly when `cs_n` is low and address bits 15:8 equal 0xD0.
- R7: With `WRITE_ONLY`=0, reads (`rd_wr_n`=1) and writes (`rd_wr_n`=0) both trigger. With `WRITE_ONLY`=1, only writes trigger.
- R8: When one access matches both the set and the clear offset, the clear wins and `dma_req_n` ends high.
- R9: Only offsets inside the spare window 0x31 to 0x3F can trigger. A set or clear offset configured outside that window, such as 0x30 or 0x2F, never changes `dma_req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, synchronous with the host bus |
| rst_n | input | 1 | Asynchronous active-low reset; forces the request released |
| phi2 | input | 1 | Host phase-2 clock; the host owns the bus while it is high |
| cs_n | input | 1 | Original active-low chip select of the video register range |
| rd_wr_n | input | 1 | Host direction: 1 = read, 0 = write |
| addr | input | ADDR_W | Host address bus |
| dma_req_n | output | 1 | Active-low bus-release request to the host DMA input |
| vid_cs_n | output | 1 | Qualified active-low chip select for the video controller |

## Verification
The bench builds four copies of the block:
- The default copy covers set, clear, reset and the chip-select narrowing.
- A copy with `WRITE_ONLY`=1 shows that reads are ignored while writes still take effect.
- A copy with the set and clear offsets both at 0x3A is the only way to present both triggers at once, so it is what reaches the clear-wins priority.
- A copy with its offsets at 0x30 and 0x2F shows that slots outside the spare window stay inert even when they are configured.

// File: rtl/bus_takeover_reg.sv
module bus_takeover_reg #(
  parameter int ADDR_W     = 16,
  parameter int OFS_W      = 8,
  parameter int VID_PAGE   = 'hD0,
  parameter int SET_OFS    = 'h31,
  parameter int CLR_OFS    = 'h32,
  parameter int SPARE_LO   = 'h31,
  parameter int SPARE_HI   = 'h3F,
  parameter bit WRITE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cs_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              dma_req_n,
  output logic              vid_cs_n
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam bit SET_OK = (SET_OFS >= SPARE_LO) && (SET_OFS <= SPARE_HI);
  localparam bit CLR_OK = (CLR_OFS >= SPARE_LO) && (CLR_OFS <= SPARE_HI);

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic              in_page, qual, set_hit, clr_hit, req_q;

  assign page    = addr[ADDR_W-1:OFS_W];
  assign ofs     = addr[OFS_W-1:0];
  assign in_page = (page == PAGE_W'(VID_PAGE));
  assign qual    = !cs_n && phi2 && in_page && (!WRITE_ONLY || !rd_wr_n);
  assign set_hit = qual && SET_OK && (ofs == OFS_W'(SET_OFS));
  assign clr_hit = qual && CLR_OK && (ofs == OFS_W'(CLR_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (clr_hit) req_q <= 1'b0;
    else if (set_hit) req_q <= 1'b1;
  end

  assign dma_req_n = ~req_q;
  assign vid_cs_n  = cs_n | ~in_page;

  a_r1_reset_released: assert property (@(posedge clk) !rst_n |-> dma_req_n);
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit && !clr_hit |=> !dma_req_n);
  a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> dma_req_n);
  a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !set_hit && !clr_hit |=> $stable(dma_req_n));
  a_r5_unqualified_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !phi2) |=> $stable(dma_req_n));
  a_r6_vid_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_cs_n |-> !cs_n);
  a_r7_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_ONLY && rd_wr_n) |=> $stable(dma_req_n));
endmodule

// File: tb/tb_bus_takeover_reg.sv
module tb_bus_takeover_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic phi2 = 1'b0, cs_n = 1'b1, rd_wr_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [3:0] dreq_n;
  logic vid_cs_n, unused_v1, unused_v2, unused_v3;
  int checks = 0, fails = 0;
  string last_tag = "R1";
  bit model [4];
  int m_set [4] = '{'h31, 'h31, 'h3A, 'h30};
  int m_clr [4] = '{'h32, 'h32, 'h3A, 'h2F};
  bit m_wo  [4] = '{1'b0, 1'b1, 1'b0, 1'b0};

  always #2 clk = ~clk;

  bus_takeover_reg dut (.clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_n(cs_n),
    .rd_wr_n(rd_wr_n), .addr(addr), .dma_req_n(dreq_n[0]), .vid_cs_n(vid_cs_n));
  bus_takeover_reg #(.WRITE_ONLY(1'b1)) dut_wo (.clk(clk), .rst_n(rst_n), .phi2(phi2),
    .cs_n(cs_n), .rd_wr_n(rd_wr_n), .addr(addr), .dma_req_n(dreq_n[1]), .vid_cs_n(unused_v1));
  bus_takeover_reg #(.SET_OFS('h3A), .CLR_OFS('h3A)) dut_pri (.clk(clk), .rst_n(rst_n),
    .phi2(phi2), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .addr(addr), .dma_req_n(dreq_n[2]),
    .vid_cs_n(unused_v2));
  bus_takeover_reg #(.SET_OFS('h30), .CLR_OFS('h2F)) dut_bad (.clk(clk), .rst_n(rst_n),
    .phi2(phi2), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .addr(addr), .dma_req_n(dreq_n[3]),
    .vid_cs_n(unused_v3));

  function automatic bit spare(int o);
    return (o >= 'h31) && (o <= 'h3F);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) model[i] <= 1'b0;
      else if (!cs_n && phi2 && addr[15:8] == 8'hD0 && (!m_wo[i] || !rd_wr_n)) begin
        if (spare(m_clr[i]) && addr[7:0] == m_clr[i][7:0]) model[i] <= 1'b0;
        else if (spare(m_set[i]) && addr[7:0] == m_set[i][7:0]) model[i] <= 1'b1;
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic c, input logic p,
                      input logic rw, input string tag);
    @(negedge clk);
    for (int i = 0; i < 4; i++) check(last_tag, dreq_n[i], ~model[i]);
    addr = a; cs_n = c; phi2 = p; rd_wr_n = rw;
    last_tag = tag;
    #1;
    check({tag, "/R6"}, vid_cs_n, c | (a[15:8] != 8'hD0));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    step(16'hD031, 1'b0, 1'b1, 1'b0, "R1");
    step(16'hD031, 1'b0, 1'b1, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(16'h0000, 1'b1, 1'b0, 1'b1, "R1");
    step(16'hD031, 1'b0, 1'b1, 1'b1, "R2");
    step(16'hD02F, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD030, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD033, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD03F, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD132, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD332, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD032, 1'b1, 1'b1, 1'b0, "R5");
    step(16'hD032, 1'b0, 1'b0, 1'b0, "R5");
    step(16'hD032, 1'b0, 1'b1, 1'b1, "R3");
    step(16'hD131, 1'b0, 1'b1, 1'b0, "R4");
    step(16'hD031, 1'b1, 1'b1, 1'b0, "R5");
    step(16'hD031, 1'b0, 1'b0, 1'b0, "R5");
    step(16'hD031, 1'b0, 1'b1, 1'b0, "R7");
    step(16'hD032, 1'b0, 1'b1, 1'b1, "R7");
    step(16'hD0FF, 1'b0, 1'b1, 1'b1, "R6");
    step(16'hD100, 1'b0, 1'b1, 1'b1, "R6");
    step(16'hD3FF, 1'b0, 1'b0, 1'b1, "R6");
    step(16'hD000, 1'b1, 1'b1, 1'b1, "R6");
    step(16'hD032, 1'b0, 1'b1, 1'b0, "R3");
    step(16'hD03A, 1'b0, 1'b1, 1'b0, "R8");
    step(16'hD03A, 1'b0, 1'b1, 1'b1, "R8");
    step(16'hD030, 1'b0, 1'b1, 1'b0, "R9");
    step(16'hD02F, 1'b0, 1'b1, 1'b0, "R9");
    step(16'hD031, 1'b0, 1'b1, 1'b0, "R2");
    step(16'h1234, 1'b1, 1'b0, 1'b1, "R4");
    @(negedge clk); rst_n = 1'b0;
    step(16'h1234, 1'b1, 1'b0, 1'b1, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(16'h1234, 1'b1, 1'b0, 1'b1, "R1");
    step(16'h1234, 1'b1, 1'b0, 1'b1, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule